// File: doc/BRIEF.md
# Read-Response ASCII Packet Transmit Bridge

This block sits between an internal register bus and a byte-wide UART transmitter. A read response from the bus is a 16-bit word. The block turns each one into a short text packet: the letter `D`, the word as uppercase hexadecimal digits with the most significant nibble first, then a carriage return and a line feed. The packet is handed to the byte transmitter one byte at a time. The block raises a start request and steps to the next byte each time the transmitter reports that a byte is done.

A serial link can drain slightly slower than the requester issues reads. For that reason the block holds two words. The active word is the one being sent. A spare word is caught while the active packet is still going out. When the active packet ends, the spare word is promoted in the same clock, so the link never sits idle between packets. If a third response arrives while both slots are occupied, that word is discarded and a sticky overflow flag records the loss.

The data width is a parameter and must be a multiple of four. The packet length follows from it: one lead byte, one byte per nibble, and two terminator bytes. With the default width of 16 that gives 7 bytes.

Top module: `uart_rsp_tx_bridge`

## Requirements
- R1: A bus word is accepted only when `bus_valid` is 1 and `bus_rw` is 0. A cycle with `bus_rw` = 1, or with `bus_valid` = 0, produces no packet and leaves `tx_start` low while the bridge is idle.
- R2: `tx_start` is high exactly while a packet is pending. It rises on the clock edge at which an idle bridge accepts a read word.
- R3: Each packet is 7 bytes, in this order: 0x44 (`D`), then four hex digits of the word with bits 15:12 first, each encoded as 0x30–0x39 for 0–9 and 0x41–0x46 for A–F, then 0x0D, then 0x0A.
- R4: The byte on `tx_byte` advances to the next packet byte only on a clock edge where `tx_done` is 1 while `tx_start` is 1. A `tx_done` pulse while the bridge is idle is ignored.
- R5: After the `tx_done` of the last byte, `tx_start` falls on that edge unless another word is pending.
- R6: A read word accepted while a packet is in progress is held and sent as the next packet, unchanged.
- R7: When a packet ends with a word held, `tx_start` stays high with no idle cycle, and `tx_byte` restarts at 0x44 for the held word.
- R8: A read word presented in the same cycle as the final `tx_done` is kept, whether or not a word was already held.
- R9: A read word that arrives while both the active and the held slot are full is dropped, and `overflow` goes to 1 and stays 1 until reset.
- R10: A synchronous reset (`rst` = 1 at a rising edge) empties both slots, returns the byte position to the lead byte, and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus response strobe |
| bus_rw | input | 1 | 0 = read response (reply wanted), 1 = write (no reply) |
| bus_data | input | 16 | Read-response data word |
| tx_start | output | 1 | Request to the byte transmitter: a byte is ready |
| tx_byte | output | 8 | Byte for the transmitter to send |
| tx_done | input | 1 | One-cycle pulse from the transmitter: current byte finished |
| overflow | output | 1 | Sticky flag: a read word was dropped |

## Verification
The hardest case to reach from the ports is a read that lands in the exact cycle of the final `tx_done` while the spare slot is already full. In that cycle the held word must be promoted and the new word must take the spare slot, with nothing lost and nothing flagged. The stimulus fills both slots with `tx_done` held low, then pulses `tx_done`. It follows the reference model's byte position and presents the extra read only on the cycle whose pulse completes byte 6. A further sweep mixes random reads, writes and transmitter pacing, so that this boundary and the overflow boundary are also met by chance.

// File: rtl/rsp_bridge_pkg.sv
package rsp_bridge_pkg;

   localparam logic [7:0] LEAD_CHAR = 8'h44;
   localparam logic [7:0] CR_CHAR   = 8'h0D;
   localparam logic [7:0] LF_CHAR   = 8'h0A;

   typedef enum logic [1:0] {
      ROLE_LEAD,
      ROLE_DIGIT,
      ROLE_CR,
      ROLE_LF
   } byte_role_e;

   function automatic logic [7:0] nib_to_ascii(input logic [3:0] n, input bit upper);
      if (n < 4'd10)
         return 8'h30 + {4'h0, n};
      else if (upper)
         return 8'h37 + {4'h0, n};
      else
         return 8'h57 + {4'h0, n};
   endfunction

endpackage

// File: rtl/rsp_two_slot.sv
module rsp_two_slot #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_word,
   input  logic              pop,
   output logic              act_vld,
   output logic [DATA_W-1:0] act_word,
   output logic              ovf
);

   logic              spare_vld;
   logic [DATA_W-1:0] spare_word;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_vld   <= 1'b0;
         spare_vld <= 1'b0;
         ovf       <= 1'b0;
      end else if (!act_vld) begin
         if (push) begin
            act_vld  <= 1'b1;
            act_word <= push_word;
         end
      end else if (pop) begin
         if (spare_vld) begin
            act_word <= spare_word;
            if (push)
               spare_word <= push_word;
            else
               spare_vld <= 1'b0;
         end else if (push) begin
            act_word <= push_word;
         end else begin
            act_vld <= 1'b0;
         end
      end else if (push) begin
         if (!spare_vld) begin
            spare_vld  <= 1'b1;
            spare_word <= push_word;
         end else begin
            ovf <= 1'b1;
         end
      end
   end

   AST_SPARE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
      spare_vld |-> act_vld);                                     // R6
   AST_HANDOFF_NO_GAP: assert property (@(posedge clk) disable iff (rst)
      (pop && spare_vld) |=> act_vld);                            // R7
   AST_LAST_CYCLE_PUSH_KEPT: assert property (@(posedge clk) disable iff (rst)
      (act_vld && pop && push) |=> act_vld);                      // R8
   AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);                                               // R9

endmodule

// File: rtl/rsp_pkt_seq.sv
module rsp_pkt_seq
   import rsp_bridge_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit HEX_UPPER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              busy,
   input  logic              tx_done,
   input  logic [DATA_W-1:0] word,
   output logic [7:0]        tx_byte,
   output logic              pkt_last
);

   localparam int DIGITS   = DATA_W / 4;
   localparam int PKT_LEN  = DIGITS + 3;
   localparam int IDX_W    = $clog2(PKT_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

   logic [IDX_W-1:0] idx;
   logic             advance;
   logic [7:0]       dig_chr [DIGITS];
   byte_role_e       role;

   assign advance  = busy & tx_done;
   assign pkt_last = advance & (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (rst)
         idx <= '0;
      else if (advance)
         idx <= pkt_last ? '0 : idx + 1'b1;
   end

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      assign dig_chr[g] = nib_to_ascii(word[DATA_W-1-4*g -: 4], HEX_UPPER);
   end

   always_comb begin
      if (idx == '0)
         role = ROLE_LEAD;
      else if (idx == LAST_IDX)
         role = ROLE_LF;
      else if (idx == LAST_IDX - 1'b1)
         role = ROLE_CR;
      else
         role = ROLE_DIGIT;
   end

   always_comb begin
      tx_byte = LEAD_CHAR;
      case (role)
         ROLE_LEAD: tx_byte = LEAD_CHAR;
         ROLE_CR:   tx_byte = CR_CHAR;
         ROLE_LF:   tx_byte = LF_CHAR;
         default: begin
            for (int k = 0; k < DIGITS; k++)
               if (int'(idx) == k + 1) tx_byte = dig_chr[k];
         end
      endcase
   end

   AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !advance |=> $stable(idx));                                 // R4
   AST_IDLE_AT_LEAD: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (idx == '0));                                     // R4
   AST_WRAP_TO_LEAD: assert property (@(posedge clk) disable iff (rst)
      pkt_last |=> (idx == '0));                                  // R5

endmodule

// File: rtl/uart_rsp_tx_bridge.sv
module uart_rsp_tx_bridge
   import rsp_bridge_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter bit HEX_UPPER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_valid,
   input  logic              bus_rw,
   input  logic [DATA_W-1:0] bus_data,
   output logic              tx_start,
   output logic [7:0]        tx_byte,
   input  logic              tx_done,
   output logic              overflow
);

   if ((DATA_W % 4) != 0 || DATA_W < 4) begin : g_bad_width
      $error("uart_rsp_tx_bridge: DATA_W must be a positive multiple of 4");
   end

   logic              take_rd;
   logic              act_vld;
   logic [DATA_W-1:0] act_word;
   logic              pkt_last;

   assign take_rd  = bus_valid & ~bus_rw;
   assign tx_start = act_vld;

   rsp_two_slot #(.DATA_W(DATA_W)) u_slots (
      .clk      (clk),
      .rst      (rst),
      .push     (take_rd),
      .push_word(bus_data),
      .pop      (pkt_last),
      .act_vld  (act_vld),
      .act_word (act_word),
      .ovf      (overflow)
   );

   rsp_pkt_seq #(.DATA_W(DATA_W), .HEX_UPPER(HEX_UPPER)) u_seq (
      .clk     (clk),
      .rst     (rst),
      .busy    (act_vld),
      .tx_done (tx_done),
      .word    (act_word),
      .tx_byte (tx_byte),
      .pkt_last(pkt_last)
   );

   AST_WRITE_NO_REPLY: assert property (@(posedge clk) disable iff (rst)
      (!tx_start && !(bus_valid && !bus_rw)) |=> !tx_start);      // R1
   AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!tx_start && bus_valid && !bus_rw) |=> tx_start);          // R2
   AST_LEAD_BYTE_FIRST: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_start) |-> (tx_byte == LEAD_CHAR));                // R3

endmodule

// File: tb/test_uart_rsp_tx_bridge.sv
module test_uart_rsp_tx_bridge;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_valid = 1'b0;
   logic        bus_rw = 1'b0;
   logic [15:0] bus_data = '0;
   logic        tx_done = 1'b0;
   logic        tx_start;
   logic [7:0]  tx_byte;
   logic        overflow;

   always #4 clk = ~clk;   // 125 MHz

   uart_rsp_tx_bridge i_uart_rsp_tx_bridge (
      .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_rw(bus_rw),
      .bus_data(bus_data), .tx_start(tx_start), .tx_byte(tx_byte),
      .tx_done(tx_done), .overflow(overflow)
   );

   // behavioural reference model
   logic [15:0] mq[$];
   int          midx = 0;
   bit          movf = 1'b0;
   int          vectors = 0;
   int          miscompares = 0;
   string       cur_req = "R10";
   bit          finished = 1'b0;

   function automatic logic [7:0] exp_char(logic [15:0] w, int i);
      int nib;
      if (i == 0) return 8'h44;
      if (i == 5) return 8'h0D;
      if (i == 6) return 8'h0A;
      nib = int'((w >> (4 * (4 - i))) & 16'hF);
      return (nib < 10) ? 8'(48 + nib) : 8'(55 + nib);
   endfunction

   task automatic check(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step();
      bit acc;
      @(posedge clk);
      if (rst) begin
         mq.delete();
         midx = 0;
         movf = 1'b0;
      end else begin
         acc = bus_valid && !bus_rw;
         if (mq.size() > 0 && tx_done) begin
            if (midx == 6) begin
               midx = 0;
               void'(mq.pop_front());
            end else begin
               midx++;
            end
         end
         if (acc) begin
            if (mq.size() < 2) mq.push_back(bus_data);
            else movf = 1'b1;
         end
      end
      @(negedge clk);
      check(cur_req, "tx_start", int'(tx_start), int'(mq.size() > 0));
      if (mq.size() > 0)
         check(cur_req, "tx_byte", int'(tx_byte), int'(exp_char(mq[0], midx)));
      check(cur_req, "overflow", int'(overflow), int'(movf));
   endtask

   task automatic idle_inputs();
      bus_valid = 1'b0; bus_rw = 1'b0; tx_done = 1'b0;
   endtask

   task automatic send_read(logic [15:0] w);
      bus_valid = 1'b1; bus_rw = 1'b0; bus_data = w;
      step();
      bus_valid = 1'b0;
   endtask

   task automatic drain(int period);
      int c = 0;
      while (mq.size() > 0) begin
         tx_done = ((c % period) == period - 1);
         c++;
         step();
      end
      tx_done = 1'b0;
      step();
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R10: reset state
      cur_req = "R10";
      for (int i = 0; i < 3; i++) step();
      rst = 1'b0;
      step();

      // R1: writes and invalid cycles produce nothing
      cur_req = "R1";
      for (int i = 0; i < 12; i++) begin
         bus_valid = (i % 3) != 2;
         bus_rw    = (i % 3) != 2;
         bus_data  = 16'(i * 16'h1111);
         step();
      end
      bus_valid = 1'b0; bus_rw = 1'b0; bus_data = 16'h5555;
      for (int i = 0; i < 4; i++) step();

      // R4: done pulses while idle are ignored
      cur_req = "R4";
      tx_done = 1'b1;
      for (int i = 0; i < 5; i++) step();
      tx_done = 1'b0;

      // R2/R3/R5: single packets, several words, sparse done
      cur_req = "R3";
      send_read(16'hA5F0); drain(3);
      send_read(16'h1234); drain(1);
      send_read(16'hFFFF); drain(4);
      send_read(16'h0000); drain(2);
      cur_req = "R5";
      send_read(16'h9ABC); drain(5);

      // R4: long stalls of done mid-packet
      cur_req = "R4";
      send_read(16'h7E1D);
      for (int i = 0; i < 7; i++) begin
         for (int j = 0; j < 6; j++) step();
         tx_done = 1'b1; step(); tx_done = 1'b0;
      end
      step();

      // R6: read during transmission is held
      cur_req = "R6";
      send_read(16'h0F0F);
      tx_done = 1'b1; step(); tx_done = 1'b0;
      send_read(16'hBEEF);
      drain(2);

      // R7: back-to-back with done every cycle, no idle gap
      cur_req = "R7";
      send_read(16'h1357);
      send_read(16'h2468);
      drain(1);

      // R8: read on the final-done cycle, spare empty then spare full
      cur_req = "R8";
      send_read(16'hC0DE);
      tx_done = 1'b1;
      while (midx != 6) step();
      bus_valid = 1'b1; bus_data = 16'hD00D; step(); bus_valid = 1'b0;
      drain(1);
      send_read(16'hAAAA);
      send_read(16'hBBBB);
      tx_done = 1'b1;
      while (!(midx == 6 && mq.size() == 2)) step();
      bus_valid = 1'b1; bus_data = 16'hCCCC; step(); bus_valid = 1'b0;
      drain(2);

      // R9: third word while both full is dropped, flag sticks
      cur_req = "R9";
      send_read(16'h1111);
      send_read(16'h2222);
      send_read(16'h3333);
      drain(2);
      for (int i = 0; i < 5; i++) step();

      // random sweep (R2, R5, R8, R9 boundaries by chance)
      cur_req = "R5";
      for (int i = 0; i < 4000; i++) begin
         bus_valid = ($urandom % 4) == 0;
         bus_rw    = ($urandom % 3) == 0;
         bus_data  = 16'($urandom);
         tx_done   = ($urandom % 3) == 0;
         step();
      end
      idle_inputs();
      drain(1);

      // R10: reset mid-packet clears everything
      cur_req = "R10";
      send_read(16'h4321);
      send_read(16'h8765);
      tx_done = 1'b1; step(); step(); tx_done = 1'b0;
      rst = 1'b1; step(); rst = 1'b0;
      step(); step();
      cur_req = "R2";
      send_read(16'h6A2F);
      drain(1);

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule